// File: doc/BRIEF.md
# D-Channel Transmit Distributor

This block connects one serial HDLC transmitter to the downstream direction of a time-division line-card frame. The frame is 256 bits long and is split into 32 eight-bit time slots. It serves 8 subscribers, and each subscriber owns a group of 4 consecutive slots. The last slot of each group carries that subscriber's 16-kbit/s D-channel in its two most significant bits, bit 7 and bit 6. The block counts frame positions from a frame-sync pulse. At the right moment it issues a transmit strobe to the HDLC source and writes the sampled bit into the downstream serial stream. Bits it does not touch pass through from the normal downstream path.

In single mode one subscriber index picks the destination. In broadcast mode a mask picks any set of destinations. The block strobes the transmitter twice at the start of each frame and loads the two bits into a small buffer. It then writes the buffer into the D-channel of every chosen subscriber. A subscriber can take data only when its two control-memory codes mark it as an arbiter destination. When the HDLC source reports that it has nothing to send, the block inserts all-ones timefill in place of the data bit. Changes to the selection take effect at the next frame start.

Top module: `dch_tx_distrib`

## Requirements
- R1: `fsync` high marks frame bit 0. The position then counts up by one per clock and wraps from 255 to 0. No strobe occurs and no bit is replaced before the first `fsync` after reset.
- R2: In single mode (`bcast_en`=0), the serial bits at frame offsets 8*(4s+3) and 8*(4s+3)+1 are replaced by the sampled transmitter bits, where s is the selected subscriber. These offsets are bit 7 and bit 6 of that subscriber's D slot. `dn_out` shows each input bit, replaced or not, one clock after it is presented on `dn_in`.
- R3: In single mode `tx_strobe` is high on exactly those two clocks of each frame. `tx_data` is sampled on the same clock as each strobe, so the bit strobed first goes to bit 7 and the bit strobed second goes to bit 6.
- R4: While `tx_idle` is high, every inserted bit is 1 (timefill), whatever the value of `tx_data`.
- R5: In broadcast mode `tx_strobe` is high at frame bits 0 and 1, and only when at least one subscriber is a valid destination. The two sampled bits are then written into bit 7 and bit 6 of the D slot of every subscriber s that has `bcast_mask[s]`=1 and is eligible.
- R6: In broadcast mode with `tx_idle` high, the buffer is loaded with ones, and every selected subscriber receives 1,1.
- R7: Subscriber s is eligible only when `cm_code[8s+7:8s+4]`=4'b1010 (even-slot code) and `cm_code[8s+3:8s]`=4'b1011 (odd-slot code). A subscriber that is not eligible gets no insertion, and in single mode it gets no strobe.
- R8: Every bit that is not a replaced D-channel bit, including bits 5..0 of a D slot and the slots of subscribers that are not selected, equals `dn_in` delayed by one clock.
- R9: `sel_sub`, `bcast_en`, `bcast_mask` and `cm_code` are captured only on an `fsync` clock. A change in the middle of a frame has no effect until the next frame.
- R10: While `rst` is high, `tx_strobe` is 0. After a reset clock, `dn_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one frame bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | High on the clock of frame bit 0 |
| dn_in | input | 1 | Downstream serial data from the normal path |
| dn_out | output | 1 | Downstream serial data with D-channel bits inserted |
| tx_strobe | output | 1 | Bit request to the HDLC transmitter |
| tx_data | input | 1 | Serial bit from the HDLC transmitter, sampled with the strobe |
| tx_idle | input | 1 | Transmitter has no data; insert timefill ones |
| sel_sub | input | 3 | Destination subscriber in single mode |
| bcast_en | input | 1 | Selects broadcast mode |
| bcast_mask | input | 8 | Destination set in broadcast mode, bit s = subscriber s |
| cm_code | input | 64 | Per-subscriber even/odd control-memory codes |

## Verification
The bench targets these cases, and each one breaks a wrong design in a visible way:
- The D slot of the highest subscriber sits right before the frame wrap. An off-by-one in position decoding moves the replaced bits into bit 5 or into the next group.
- One subscriber carries a bad odd-slot code. A design that checks only one of the two codes strobes and writes into that subscriber.
- The selection changes in the middle of a frame. A design that does not hold the selection until the frame start splits the bit pair or changes mode too early.
- Broadcast with timefill, and broadcast with an empty mask. A design that routes live data around the buffer shows up in the first case; a design that strobes with no destination shows up in the second.

// File: rtl/dca_pkg.sv
package dca_pkg;

    localparam logic [3:0] CM_EVEN_OK = 4'b1010;
    localparam logic [3:0] CM_ODD_OK  = 4'b1011;
    localparam int         CM_W       = 8;

    typedef enum logic {
        DIST_SINGLE = 1'b0,
        DIST_BCAST  = 1'b1
    } dist_mode_e;

    // upper nibble drives the even slot, lower nibble the odd slot
    function automatic logic cm_pair_ok(input logic [CM_W-1:0] code);
        return (code[7:4] == CM_EVEN_OK) && (code[3:0] == CM_ODD_OK);
    endfunction

    // timefill forces a one whenever the source has nothing to send
    function automatic logic fill_bit(input logic idle, input logic data);
        return idle | data;
    endfunction

endpackage

// File: rtl/dca_frame_pos.sv
module dca_frame_pos #(
    parameter int NSUB          = 8,
    parameter int SLOTS_PER_SUB = 4,
    parameter int SLOT_BITS     = 8,
    parameter int DSLOT         = 3,
    localparam int FRAME_BITS   = NSUB * SLOTS_PER_SUB * SLOT_BITS,
    localparam int POS_W        = $clog2(FRAME_BITS),
    localparam int SUB_W        = (NSUB > 1) ? $clog2(NSUB) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fsync,
    output logic [POS_W-1:0] pos_o,
    output logic             framed_o,
    output logic [SUB_W-1:0] sub_o,
    output logic             dbit_hit_o,
    output logic             dbit_idx_o,
    output logic             head_o,
    output logic             head_idx_o
);

    logic [POS_W-1:0] cnt_q;
    logic [POS_W-1:0] pos;
    logic             framed_q;

    always_comb begin
        pos = fsync ? '0 : cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            framed_q <= 1'b0;
        end else begin
            cnt_q    <= (pos == POS_W'(FRAME_BITS - 1)) ? '0 : pos + 1'b1;
            framed_q <= framed_q | fsync;
        end
    end

    int unsigned p;
    int unsigned slot;
    int unsigned bit_in_slot;

    always_comb begin
        p           = {{(32 - POS_W){1'b0}}, pos};
        slot        = p / SLOT_BITS;
        bit_in_slot = p % SLOT_BITS;
        sub_o       = SUB_W'(slot / SLOTS_PER_SUB);
        dbit_hit_o  = ((slot % SLOTS_PER_SUB) == DSLOT) && (bit_in_slot < 2);
        dbit_idx_o  = (bit_in_slot == 1);
        head_o      = (p < 2);
        head_idx_o  = (p == 1);
    end

    assign pos_o    = pos;
    assign framed_o = !rst && (fsync || framed_q);

    // R1
    frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!fsync && cnt_q == POS_W'(FRAME_BITS - 1)) |=> (cnt_q == '0));

endmodule

// File: rtl/dca_cfg_latch.sv
module dca_cfg_latch
    import dca_pkg::*;
#(
    parameter int NSUB   = 8,
    localparam int SUB_W = (NSUB > 1) ? $clog2(NSUB) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fsync,
    input  logic [SUB_W-1:0]     sel_in,
    input  logic                 bc_in,
    input  logic [NSUB-1:0]      mask_in,
    input  logic [NSUB*CM_W-1:0] cm_in,
    output dist_mode_e           mode_o,
    output logic [NSUB-1:0]      dest_o
);

    logic [NSUB-1:0] elig;
    logic [NSUB-1:0] dest_next, dest_q;
    dist_mode_e      mode_next, mode_q;

    for (genvar g = 0; g < NSUB; g++) begin : g_elig
        assign elig[g] = cm_pair_ok(cm_in[g*CM_W +: CM_W]);
    end

    always_comb begin
        mode_next = bc_in ? DIST_BCAST : DIST_SINGLE;
        if (bc_in) dest_next = mask_in & elig;
        else       dest_next = elig & (NSUB'(1) << sel_in);
        mode_o = fsync ? mode_next : mode_q;
        dest_o = fsync ? dest_next : dest_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= DIST_SINGLE;
            dest_q <= '0;
        end else begin
            mode_q <= mode_o;
            dest_q <= dest_o;
        end
    end

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fsync |-> (mode_o == mode_q && dest_o == dest_q));

endmodule

// File: rtl/dca_bcast_buf.sv
module dca_bcast_buf #(
    parameter int PAIR = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            idx,
    input  logic            bit_in,
    output logic [PAIR-1:0] buf_o
);

    logic [PAIR-1:0] buf_q;

    // buf_q[PAIR-1] holds bit 7 (first strobe), buf_q[0] holds bit 6
    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '1;
        end else if (load) begin
            if (idx) buf_q[0]        <= bit_in;
            else     buf_q[PAIR-1]   <= bit_in;
        end
    end

    assign buf_o = buf_q;

endmodule

// File: rtl/dch_tx_distrib.sv
module dch_tx_distrib
    import dca_pkg::*;
#(
    parameter int NSUB          = 8,
    parameter int SLOTS_PER_SUB = 4,
    parameter int SLOT_BITS     = 8,
    parameter int DSLOT         = 3,
    localparam int FRAME_BITS   = NSUB * SLOTS_PER_SUB * SLOT_BITS,
    localparam int POS_W        = $clog2(FRAME_BITS),
    localparam int SUB_W        = (NSUB > 1) ? $clog2(NSUB) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fsync,
    input  logic                 dn_in,
    output logic                 dn_out,
    output logic                 tx_strobe,
    input  logic                 tx_data,
    input  logic                 tx_idle,
    input  logic [SUB_W-1:0]     sel_sub,
    input  logic                 bcast_en,
    input  logic [NSUB-1:0]      bcast_mask,
    input  logic [NSUB*CM_W-1:0] cm_code
);

    logic [POS_W-1:0] pos;
    logic             framed;
    logic [SUB_W-1:0] sub;
    logic             dbit_hit, dbit_idx, head, head_idx;
    dist_mode_e       mode;
    logic [NSUB-1:0]  dest;
    logic [1:0]       bbuf;
    logic             ins, ins_bit, bload, dn_q;

    dca_frame_pos #(
        .NSUB(NSUB), .SLOTS_PER_SUB(SLOTS_PER_SUB),
        .SLOT_BITS(SLOT_BITS), .DSLOT(DSLOT)
    ) u_pos (
        .clk(clk), .rst(rst), .fsync(fsync),
        .pos_o(pos), .framed_o(framed), .sub_o(sub),
        .dbit_hit_o(dbit_hit), .dbit_idx_o(dbit_idx),
        .head_o(head), .head_idx_o(head_idx)
    );

    dca_cfg_latch #(.NSUB(NSUB)) u_cfg (
        .clk(clk), .rst(rst), .fsync(fsync),
        .sel_in(sel_sub), .bc_in(bcast_en), .mask_in(bcast_mask),
        .cm_in(cm_code), .mode_o(mode), .dest_o(dest)
    );

    dca_bcast_buf #(.PAIR(2)) u_buf (
        .clk(clk), .rst(rst), .load(bload), .idx(head_idx),
        .bit_in(fill_bit(tx_idle, tx_data)), .buf_o(bbuf)
    );

    always_comb begin
        ins   = framed && dbit_hit && dest[sub];
        bload = framed && (mode == DIST_BCAST) && head && (|dest);
        if (mode == DIST_SINGLE) begin
            tx_strobe = ins;
            ins_bit   = fill_bit(tx_idle, tx_data);
        end else begin
            tx_strobe = bload;
            ins_bit   = dbit_idx ? bbuf[0] : bbuf[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) dn_q <= 1'b1;
        else     dn_q <= ins ? ins_bit : dn_in;
    end

    assign dn_out = dn_q;

    // R3
    pair_open_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_strobe) |=> (tx_strobe || fsync));

    // R3
    pair_close_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_strobe && $past(tx_strobe)) |=> (!tx_strobe || fsync));

    // R5
    bcast_head_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_strobe && mode == DIST_BCAST) |-> (pos < POS_W'(2)));

    // R8
    passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ins)) |-> (dn_out == $past(dn_in)));

    // R4
    idle_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tx_strobe && tx_idle && mode == DIST_SINGLE)) |-> dn_out);

endmodule

// File: tb/dch_tx_distrib_tb.sv
module dch_tx_distrib_tb;

    localparam int NSUB    = 8;
    localparam int FRAME   = 256;
    localparam int START   = 12;
    localparam int END_RST = START + 9 * FRAME;
    localparam int NCYC    = END_RST + 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              fsync = 1'b0;
    logic              dn_in = 1'b0;
    logic              dn_out;
    logic              tx_strobe;
    logic              tx_data = 1'b0;
    logic              tx_idle = 1'b0;
    logic [2:0]        sel_sub = 3'd3;
    logic              bcast_en = 1'b0;
    logic [NSUB-1:0]   bcast_mask = '0;
    logic [NSUB*8-1:0] cm_code;

    always #10 clk = ~clk;

    dch_tx_distrib u_dut (
        .clk(clk), .rst(rst), .fsync(fsync), .dn_in(dn_in), .dn_out(dn_out),
        .tx_strobe(tx_strobe), .tx_data(tx_data), .tx_idle(tx_idle),
        .sel_sub(sel_sub), .bcast_en(bcast_en), .bcast_mask(bcast_mask),
        .cm_code(cm_code)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference state
    int        m_cnt = 0;
    bit        m_framed = 0;
    bit        m_bc = 0;
    int        m_sel = 0;
    bit [7:0]  m_mask = '0;
    bit [7:0]  m_dest = '0;
    bit        m_buf [2] = '{1'b1, 1'b1};
    bit        m_bufidle = 1'b1;
    bit        exp_out = 1'b1;
    string     exp_tag = "R10";

    function automatic bit code_ok(input logic [7:0] c);
        return c == 8'b1010_1011;
    endfunction

    initial begin
        for (int s = 0; s < NSUB; s++)
            cm_code[s*8 +: 8] = (s == 5) ? 8'b1010_1111 : 8'b1010_1011;
    end

    initial begin : main
        logic [15:0] lfsr = 16'hACE1;
        for (int k = 0; k < NCYC; k++) begin
            int    fr, fp, pos, slot, b, sub;
            bit    framed, dhit, ins, es, aimed;
            string note;
            @(negedge clk);
            chk(dn_out === exp_out, {exp_tag, " dn_out"}, int'(dn_out), int'(exp_out));

            lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tx_data = lfsr[0];
            dn_in   = lfsr[7];
            rst     = (k < 4) || (k >= END_RST && k < END_RST + 3);
            fr      = (k >= START) ? (k - START) / FRAME : -1;
            fp      = (k >= START) ? (k - START) % FRAME : -1;
            fsync   = !rst && k >= START && k < END_RST && fp == 0;
            if (fp == 0) begin
                case (fr)
                    0: begin bcast_en = 0; sel_sub = 2; tx_idle = 0; end
                    1: begin sel_sub = 5; end                          // R7 bad odd code
                    2: begin sel_sub = 2; tx_idle = 1; end             // R4
                    3: begin bcast_en = 1; bcast_mask = 8'b1010_0101; tx_idle = 0; end
                    4: begin tx_idle = 1; end                          // R6
                    5: begin bcast_en = 0; sel_sub = 6; tx_idle = 0; end
                    7: begin bcast_en = 1; bcast_mask = 8'h00; end     // R5 no target
                    8: begin bcast_mask = 8'hFF; end
                    default: ;
                endcase
            end
            if (fr == 5 && fp == 100) sel_sub = 1;                     // R9 mid-frame
            if (fr == 8 && fp == 50) begin bcast_en = 0; sel_sub = 0; end // R9
            note = (fr == 5 || fr == 8) ? " R9" : "";
            #1;

            if (rst) begin
                m_cnt = 0; m_framed = 0; m_bc = 0; m_sel = 0; m_mask = '0; m_dest = '0;
                m_buf[0] = 1; m_buf[1] = 1; m_bufidle = 1;
                chk(tx_strobe === 1'b0, "R10 strobe", int'(tx_strobe), 0);
                exp_out = 1'b1; exp_tag = "R10";
            end else begin
                pos    = fsync ? 0 : m_cnt;
                framed = fsync || m_framed;
                if (fsync) begin
                    m_bc = bcast_en; m_sel = int'(sel_sub); m_mask = bcast_mask;
                    for (int s = 0; s < NSUB; s++)
                        m_dest[s] = code_ok(cm_code[s*8 +: 8]) &&
                                    (m_bc ? m_mask[s] : (s == m_sel));
                end
                slot  = pos / 8;
                b     = pos % 8;
                sub   = slot / 4;
                dhit  = (slot % 4 == 3) && (b < 2);
                ins   = framed && dhit && m_dest[sub];
                es    = framed && (m_bc ? (pos < 2 && m_dest != 0) : ins);
                aimed = m_bc ? m_mask[sub] : (sub == m_sel);
                chk(tx_strobe === es, {m_bc ? "R5" : "R3", " strobe", note},
                    int'(tx_strobe), int'(es));
                if (framed && m_bc && pos < 2 && m_dest != 0) begin
                    m_buf[pos] = tx_idle | tx_data;
                    m_bufidle  = (pos == 0) ? tx_idle : (m_bufidle & tx_idle);
                end
                if (ins) begin
                    if (m_bc) begin
                        exp_out = m_buf[b];
                        exp_tag = m_bufidle ? "R6" : "R5";
                    end else begin
                        exp_out = tx_idle | tx_data;
                        exp_tag = tx_idle ? "R4" : "R2";
                    end
                end else begin
                    exp_out = dn_in;
                    if (!framed)                 exp_tag = "R1";
                    else if (dhit && aimed)      exp_tag = "R7";
                    else                         exp_tag = "R8";
                end
                exp_tag  = {exp_tag, note};
                m_cnt    = (pos + 1) % FRAME;
                m_framed = framed;
            end
        end
        @(negedge clk);
        chk(dn_out === exp_out, {exp_tag, " dn_out"}, int'(dn_out), int'(exp_out));
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (NCYC + 200) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule